// File: doc/BRIEF.md
# Sample Rate Ratio Meter

This block measures how fast the incoming audio stream runs compared with the local output stream. It runs on the output master clock, which is assumed to be exactly 256 times the output sample rate. It counts master-clock cycles between successive input frame strobes, so one frame period yields 256·Fso/Fsi. That count is scaled to an unsigned fixed-point ratio with two integer bits and six fraction bits, and it saturates at the all-ones code.

The frame strobe comes from the recovered input clock domain. It is resynchronised and edge-detected before use. A lock flag from the clock-recovery loop gates the measurement. The ratio is only marked valid once the loop is locked and one whole frame has been timed since lock was gained. A host reads `ratioOut` and `ratioValid` directly. The value is refreshed once per input frame with no hysteresis, so jitter on either clock may make the lowest bit alternate between frames.

Top module: `rate_ratio_meter`

## Requirements
- R1: `ratioOut` encodes Fso/Fsi as unsigned fixed point. Bits [7:6] are the integer part and bits [5:0] are sixty-fourths. The value equals floor(P/4), where P is the number of master-clock cycles between two consecutive synchronised strobe rising edges.
- R2: When the input frame period is exactly 256 master-clock cycles (equal rates), `ratioOut` reads 40h.
- R3: Any period of 1024 cycles or more reads FFh. A period of 1019 cycles reads FEh and a period of 1023 reads FFh.
- R4: The period counter saturates instead of wrapping. A very long period such as 5000 cycles still reads FFh.
- R5: While `pllLock` is low, a strobe edge does not update `ratioOut` and `ratioValid` stays 0. After lock rises, the first strobe edge only starts a measurement. `ratioValid` rises on the second edge, together with the new ratio.
- R6: When `pllLock` falls, `ratioValid` goes to 0 in the same cycle. After lock returns, two fresh strobe edges are needed before `ratioValid` is 1 again.
- R7: `ratioOut` changes only as a result of a strobe rising edge, and it holds its value between edges. The new value appears at the third rising clock edge after the strobe rises (two synchroniser flops plus the result register).
- R8: No hysteresis is applied. Periods of 259, 260 and 259 cycles read 40h, 41h and 40h in turn.
- R9: While `rstN` is low at a clock edge, the counter, `ratioOut` (00h) and `ratioValid` (0) are cleared.
- R10: A strobe held high for many cycles counts as a single edge. The period is measured from rising edge to rising edge.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output master clock, 256 × output sample rate |
| rstN | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | Once-per-frame strobe from the input clock domain (asynchronous) |
| pllLock | input | 1 | Lock indication from the clock-recovery loop |
| ratioOut | output | 8 | Fso/Fsi, 2 integer bits and 6 fraction bits, saturating |
| ratioValid | output | 1 | High when locked and one full frame has been timed |

## Verification
A counter that loads, steps or saturates wrongly shows up as a wrong code on `ratioOut` three clocks after the strobe edge that closes the period. A counter that wraps instead of saturating is exposed by the very long period. A corrupted result register shows either as a value change between strobe edges or as a change one cycle early or late around the edge. A wrong started or measured flag shows on `ratioValid`: it rises one frame too early after lock, or it fails to drop in the same cycle lock falls.

// File: rtl/rrm_pkg.sv
`timescale 1ns/1ps
package rrm_pkg;
  // Strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic restart;  // begin a new period count
    logic capture;  // latch the finished period into the result register
  } rrmStrobes_t;
endpackage

// File: rtl/rrm_sync.sv
`timescale 1ns/1ps
module rrm_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseEdge
);
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain[0] <= 1'b0;
    else       chain[0] <= asyncIn;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) chain[g] <= 1'b0;
      else       chain[g] <= chain[g-1];
    end
  end

  assign riseEdge = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

  // R10: a held strobe yields one single-cycle edge
  assert_edge_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    riseEdge |=> !riseEdge);
endmodule

// File: rtl/rrm_ctrl.sv
`timescale 1ns/1ps
module rrm_ctrl
  import rrm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameEdge,
  input  logic        pllLock,
  output rrmStrobes_t strobes,
  output logic        measValid
);
  logic started;   // a period start has been seen under lock
  logic measured;  // a full period has been captured under lock

  always_comb begin
    strobes.restart = frameEdge & pllLock;
    strobes.capture = frameEdge & pllLock & started;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      started  <= 1'b0;
      measured <= 1'b0;
    end else if (!pllLock) begin
      started  <= 1'b0;
      measured <= 1'b0;
    end else if (frameEdge) begin
      started <= 1'b1;
      if (started) measured <= 1'b1;
    end
  end

  assign measValid = pllLock & measured;

  // R5: completing a measurement needs an earlier start under lock
  assert_needs_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(measured) |-> $past(started));
  // R6: losing lock forgets any measurement
  assert_unlock_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    !pllLock |=> (!measured && !started));
endmodule

// File: rtl/rrm_datapath.sv
`timescale 1ns/1ps
module rrm_datapath
  import rrm_pkg::*;
#(
  parameter int MCLK_PER_FS = 256,
  parameter int INT_W       = 2,
  parameter int FRAC_W      = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rrmStrobes_t             strobes,
  output logic [INT_W+FRAC_W-1:0] ratioReg
);
  localparam int RATIO_W = INT_W + FRAC_W;
  localparam int SHIFT   = $clog2(MCLK_PER_FS) - FRAC_W;
  localparam int CNT_SAT = (1 << INT_W) * MCLK_PER_FS;
  localparam int CNT_W   = $clog2(CNT_SAT) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CNT_SAT);

  logic [CNT_W-1:0]   periodCnt;
  logic [RATIO_W-1:0] ratioNext;

  // Saturating period counter
  always_ff @(posedge clk) begin
    if (!rstN)                     periodCnt <= '0;
    else if (strobes.restart)      periodCnt <= CNT_W'(1);
    else if (periodCnt != CNT_MAX) periodCnt <= periodCnt + 1'b1;
  end

  // Scale by dropping SHIFT fraction bits, then clamp
  always_comb begin
    if (periodCnt >= CNT_MAX) ratioNext = '1;
    else                      ratioNext = periodCnt[RATIO_W+SHIFT-1:SHIFT];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               ratioReg <= '0;
    else if (strobes.capture) ratioReg <= ratioNext;
  end

  // R4: the counter never passes its saturation value
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    periodCnt <= CNT_MAX);
  // R3: a saturated period reads all ones
  assert_sat_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && periodCnt == CNT_MAX) |=> (ratioReg == '1));
  // R7: the result holds between captures
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(ratioReg));
endmodule

// File: rtl/rate_ratio_meter.sv
`timescale 1ns/1ps
module rate_ratio_meter
  import rrm_pkg::*;
#(
  parameter int MCLK_PER_FS = 256,
  parameter int INT_W       = 2,
  parameter int FRAC_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameStrobe,
  input  logic                    pllLock,
  output logic [INT_W+FRAC_W-1:0] ratioOut,
  output logic                    ratioValid
);
  logic        frameEdge;
  rrmStrobes_t strobes;

  rrm_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(frameStrobe), .riseEdge(frameEdge)
  );

  rrm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .frameEdge(frameEdge), .pllLock(pllLock),
    .strobes(strobes), .measValid(ratioValid)
  );

  rrm_datapath #(.MCLK_PER_FS(MCLK_PER_FS), .INT_W(INT_W), .FRAC_W(FRAC_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ratioReg(ratioOut)
  );

  // R6: valid is never shown without lock
  assert_valid_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    ratioValid |-> pllLock);
endmodule

// File: tb/tb_rate_ratio_meter.sv
`timescale 1ns/1ps
module tb_rate_ratio_meter;
  logic       clk = 1'b0;
  logic       rstN;
  logic       frameStrobe;
  logic       pllLock;
  logic [7:0] ratioOut;
  logic       ratioValid;

  int checks = 0;
  int errors = 0;

  localparam int NV = 12;
  localparam int VEC_P [NV] = '{256, 128, 512, 384, 64, 300, 700, 1019, 1023, 1024, 2000, 5000};
  localparam int VEC_E [NV] = '{'h40, 'h20, 'h80, 'h60, 'h10, 'h4B, 'hAF, 'hFE, 'hFF, 'hFF, 'hFF, 'hFF};

  rate_ratio_meter dut (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .pllLock(pllLock),
    .ratioOut(ratioOut), .ratioValid(ratioValid)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Rise A, period P, rise B, then sample 3 negedges after rise B; idle after.
  task automatic measure(input int p, input int hold);
    frameStrobe = 1'b1;
    repeat (hold) @(negedge clk);
    frameStrobe = 1'b0;
    repeat (p - hold) @(negedge clk);
    frameStrobe = 1'b1;
    repeat (3) @(negedge clk);
    frameStrobe = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; frameStrobe = 1'b0; pllLock = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset ratio", ratioOut, 8'h00);
    chk("R9 reset valid", {7'b0, ratioValid}, 8'h00);

    // R5: no update while unlocked
    measure(256, 2);
    chk("R5 unlocked ratio", ratioOut, 8'h00);
    chk("R5 unlocked valid", {7'b0, ratioValid}, 8'h00);

    // R5: first edge after lock only starts
    pllLock = 1'b1;
    @(negedge clk);
    frameStrobe = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 first edge valid", {7'b0, ratioValid}, 8'h00);
    frameStrobe = 1'b0;
    repeat (253) @(negedge clk);
    frameStrobe = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 second edge valid", {7'b0, ratioValid}, 8'h01);
    chk("R2 equal rates", ratioOut, 8'h40);
    frameStrobe = 1'b0;
    repeat (5) @(negedge clk);

    // R1: table walk
    for (int i = 0; i < NV; i++) begin
      measure(VEC_P[i], 2);
      chk($sformatf("R1 period %0d", VEC_P[i]), ratioOut, 8'(VEC_E[i]));
    end

    measure(1024, 2);  chk("R3 period 1024", ratioOut, 8'hFF);
    measure(1019, 2);  chk("R3 period 1019", ratioOut, 8'hFE);
    measure(5000, 2);  chk("R4 no wrap 5000", ratioOut, 8'hFF);

    // R8: lowest bit follows each frame
    measure(259, 2);  chk("R8 period 259", ratioOut, 8'h40);
    measure(260, 2);  chk("R8 period 260", ratioOut, 8'h41);
    measure(259, 2);  chk("R8 period 259 again", ratioOut, 8'h40);

    // R7: hold and latency
    measure(256, 2);
    chk("R7 hold", ratioOut, 8'h40);
    frameStrobe = 1'b1;             // rise 8 cycles after previous rise
    repeat (2) @(negedge clk);
    chk("R7 not yet updated", ratioOut, 8'h40);
    @(negedge clk);
    chk("R7 updated third edge", ratioOut, 8'h02);
    frameStrobe = 1'b0;
    repeat (197) @(negedge clk);
    frameStrobe = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 period 200", ratioOut, 8'h32);
    frameStrobe = 1'b0;
    repeat (5) @(negedge clk);

    // R10: long strobe counts once
    measure(300, 150);
    chk("R10 long strobe", ratioOut, 8'h4B);

    // R6: lock loss and relock
    pllLock = 1'b0;
    #1;
    chk("R6 valid drops", {7'b0, ratioValid}, 8'h00);
    @(negedge clk);
    pllLock = 1'b1;
    @(negedge clk);
    frameStrobe = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 relock first edge", {7'b0, ratioValid}, 8'h00);
    frameStrobe = 1'b0;
    repeat (125) @(negedge clk);
    frameStrobe = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 relock valid", {7'b0, ratioValid}, 8'h01);
    chk("R6 relock ratio", ratioOut, 8'h20);
    frameStrobe = 1'b0;

    // R9: reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    chk("R9 mid reset ratio", ratioOut, 8'h00);
    chk("R9 mid reset valid", {7'b0, ratioValid}, 8'h00);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule